// File: doc/BRIEF.md
# Interrupt-Enable and Single-Step Trap Controller

This block keeps two bits of a processor status word: the interrupt-enable flag and the single-step trap flag. At every instruction boundary, marked by a retire pulse, it decides whether to request a vector-1 debug trap or accept a pending external interrupt. A debug trap is requested when single-stepping is on or when one of the four breakpoint comparators reports a hit. An external interrupt is accepted only when the interrupt-enable flag is set.

Software changes both flags by popping a new status word into the block. A privilege check guards the interrupt-enable bit. The pop can change that bit only when the current privilege level is numerically no greater than the I/O privilege field carried in the popped word. The trap flag is always written. When an interrupt is accepted, the interrupt-enable flag is cleared in the same cycle as the accept pulse, so that a level-sensitive request cannot be taken twice.

Top module: `irq_trap_ctl`

## Requirements
- R1: After reset, the interrupt-enable and trap flags read 0, and neither irq_accept nor dbg_trap is asserted.
- R2: A pop (pop_we=1) with cur_priv <= pop_data[13:12] loads the interrupt-enable flag from pop_data[9] and the trap flag from pop_data[8]. Both values are visible on the cycle after the strobe.
- R3: A pop with cur_priv > pop_data[13:12] leaves the interrupt-enable flag unchanged and still loads the trap flag from pop_data[8].
- R4: When retire=1, ie_flag=1 and ext_irq_req=1, and no trap is due, irq_accept pulses for one cycle on the next cycle. In that same cycle ie_flag reads 0.
- R5: When ie_flag=0, ext_irq_req is ignored: irq_accept stays 0 and both flags are unchanged.
- R6: When retire=1 and tf_flag=1, dbg_trap pulses for one cycle on the next cycle.
- R7: When tf_flag=0, dbg_trap pulses after a retire only if at least one bit of bkpt_hit is 1 in that cycle.
- R8: When a trap and an interrupt are both due at the same retire, only dbg_trap pulses. ie_flag stays set, so a still-asserted request is accepted at a later retire.
- R9: Without a retire pulse, neither irq_accept nor dbg_trap is asserted, whatever the other inputs are.
- R10: If an interrupt is accepted in the same cycle as a pop, the clear from the accept takes precedence on the interrupt-enable flag, and the trap flag takes the popped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_req | input | 1 | Level-sensitive external interrupt request |
| cur_priv | input | 2 | Current privilege level, 0 most privileged |
| pop_we | input | 1 | Status-word pop strobe |
| pop_data | input | 16 | Popped status word (IOPL 13:12, IE 9, TF 8) |
| retire | input | 1 | Instruction-retire pulse |
| bkpt_hit | input | 4 | Breakpoint comparator match lines |
| ie_flag | output | 1 | Interrupt-enable flag |
| tf_flag | output | 1 | Single-step trap flag |
| irq_accept | output | 1 | External interrupt accepted (one-cycle pulse) |
| dbg_trap | output | 1 | Vector-1 trap request (one-cycle pulse) |

## Verification
The hardest situation to reach from the ports is one retire at which a pop, a live interrupt request, a breakpoint hit and the trap flag all meet. In that case the priority between trap and interrupt, and the precedence of the accept clear over the pop, decide the result. The bench first loads the flags with a privileged pop. It then sweeps every combination of flag state, request, retire and the sixteen breakpoint patterns. It also drives pops and retires in the same cycle, and it follows a trap-over-interrupt collision with a second retire to show that the interrupt is still taken.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
    typedef struct packed {
        logic ie;
        logic tf;
        logic acc;
        logic trap;
    } ctl_state_t;
endpackage

// File: rtl/irq_pop_gate.sv
module irq_pop_gate #(
    parameter int FLAG_W   = 16,
    parameter int IE_BIT   = 9,
    parameter int TF_BIT   = 8,
    parameter int IOPL_LSB = 12,
    parameter int PRIV_W   = 2
) (
    input  logic              pop_we,
    input  logic [FLAG_W-1:0] pop_data,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              ie_cur,
    input  logic              tf_cur,
    output logic              ie_next,
    output logic              tf_next
);
    localparam int IOPL_MSB = IOPL_LSB + PRIV_W - 1;

    logic [PRIV_W-1:0] iopl;
    logic              allowed;

    always_comb begin
        iopl    = pop_data[IOPL_MSB:IOPL_LSB];
        allowed = (cur_priv <= iopl);
        ie_next = ie_cur;
        tf_next = tf_cur;
        if (pop_we) begin
            tf_next = pop_data[TF_BIT];
            if (allowed) begin
                ie_next = pop_data[IE_BIT];
            end
        end
    end
endmodule

// File: rtl/irq_event_arb.sv
module irq_event_arb #(
    parameter int NUM_BKPT = 4
) (
    input  logic                retire,
    input  logic                ie_cur,
    input  logic                tf_cur,
    input  logic                ext_irq_req,
    input  logic [NUM_BKPT-1:0] bkpt_hit,
    output logic                take_trap,
    output logic                take_irq
);
    logic any_hit;

    always_comb begin
        any_hit = 1'b0;
        for (int i = 0; i < NUM_BKPT; i++) begin
            any_hit = any_hit | bkpt_hit[i];
        end
        take_trap = retire && (tf_cur || any_hit);
        take_irq  = retire && ie_cur && ext_irq_req && !take_trap;
    end
endmodule

// File: rtl/irq_trap_ctl.sv
module irq_trap_ctl #(
    parameter int FLAG_W   = 16,
    parameter int IE_BIT   = 9,
    parameter int TF_BIT   = 8,
    parameter int IOPL_LSB = 12,
    parameter int PRIV_W   = 2,
    parameter int NUM_BKPT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_irq_req,
    input  logic [PRIV_W-1:0]   cur_priv,
    input  logic                pop_we,
    input  logic [FLAG_W-1:0]   pop_data,
    input  logic                retire,
    input  logic [NUM_BKPT-1:0] bkpt_hit,
    output logic                ie_flag,
    output logic                tf_flag,
    output logic                irq_accept,
    output logic                dbg_trap
);
    import irq_trap_pkg::*;

    ctl_state_t st_d, st_q;
    logic ie_pop, tf_pop, take_trap, take_irq;

    irq_pop_gate #(
        .FLAG_W(FLAG_W), .IE_BIT(IE_BIT), .TF_BIT(TF_BIT),
        .IOPL_LSB(IOPL_LSB), .PRIV_W(PRIV_W)
    ) u_pop (
        .pop_we(pop_we), .pop_data(pop_data), .cur_priv(cur_priv),
        .ie_cur(st_q.ie), .tf_cur(st_q.tf),
        .ie_next(ie_pop), .tf_next(tf_pop)
    );

    irq_event_arb #(.NUM_BKPT(NUM_BKPT)) u_arb (
        .retire(retire), .ie_cur(st_q.ie), .tf_cur(st_q.tf),
        .ext_irq_req(ext_irq_req), .bkpt_hit(bkpt_hit),
        .take_trap(take_trap), .take_irq(take_irq)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ie   = take_irq ? 1'b0 : ie_pop;
        st_d.tf   = tf_pop;
        st_d.acc  = take_irq;
        st_d.trap = take_trap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie_flag    = st_q.ie;
    assign tf_flag    = st_q.tf;
    assign irq_accept = st_q.acc;
    assign dbg_trap   = st_q.trap;
endmodule

// File: rtl/irq_trap_chk.sv
module irq_trap_chk #(
    parameter int FLAG_W   = 16,
    parameter int IOPL_LSB = 12,
    parameter int PRIV_W   = 2,
    parameter int NUM_BKPT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ext_irq_req,
    input logic [PRIV_W-1:0]   cur_priv,
    input logic                pop_we,
    input logic [FLAG_W-1:0]   pop_data,
    input logic                retire,
    input logic [NUM_BKPT-1:0] bkpt_hit,
    input logic                ie_flag,
    input logic                tf_flag,
    input logic                irq_accept,
    input logic                dbg_trap
);
    localparam int IOPL_MSB = IOPL_LSB + PRIV_W - 1;

    assert_denied_pop_keeps_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_we && !retire && (cur_priv > pop_data[IOPL_MSB:IOPL_LSB]))
        |=> ie_flag == $past(ie_flag));

    assert_accept_clears_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> !ie_flag);

    assert_accept_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_flag && !pop_we) |=> !irq_accept);

    assert_step_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && tf_flag) |=> dbg_trap);

    assert_trap_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_accept && dbg_trap));

    assert_quiet_without_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> (!irq_accept && !dbg_trap));
endmodule

bind irq_trap_ctl irq_trap_chk #(
    .FLAG_W(FLAG_W), .IOPL_LSB(IOPL_LSB), .PRIV_W(PRIV_W), .NUM_BKPT(NUM_BKPT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_irq_req(ext_irq_req), .cur_priv(cur_priv),
    .pop_we(pop_we), .pop_data(pop_data), .retire(retire), .bkpt_hit(bkpt_hit),
    .ie_flag(ie_flag), .tf_flag(tf_flag), .irq_accept(irq_accept), .dbg_trap(dbg_trap)
);

// File: tb/test_irq_trap_ctl.sv
module test_irq_trap_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_irq_req = 1'b0;
    logic [1:0]  cur_priv = 2'd0;
    logic        pop_we = 1'b0;
    logic [15:0] pop_data = '0;
    logic        retire = 1'b0;
    logic [3:0]  bkpt_hit = '0;
    logic        ie_flag, tf_flag, irq_accept, dbg_trap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_trap_ctl i_irq_trap_ctl (
        .clk(clk), .rst_n(rst_n), .ext_irq_req(ext_irq_req), .cur_priv(cur_priv),
        .pop_we(pop_we), .pop_data(pop_data), .retire(retire), .bkpt_hit(bkpt_hit),
        .ie_flag(ie_flag), .tf_flag(tf_flag), .irq_accept(irq_accept), .dbg_trap(dbg_trap)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got ie,tf,acc,trap=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input logic [1:0] iopl, input logic ie, input logic tf);
        logic [15:0] w;
        w = '0;
        w[13:12] = iopl;
        w[9] = ie;
        w[8] = tf;
        return w;
    endfunction

    task automatic idle();
        pop_we = 0; retire = 0; ext_irq_req = 0; bkpt_hit = '0; cur_priv = 0;
    endtask

    task automatic set_flags(input logic ie, input logic tf);
        @(negedge clk);
        idle();
        pop_we = 1; cur_priv = 0; pop_data = word(2'd0, ie, tf);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {ie_flag, tf_flag, irq_accept, dbg_trap}, 4'b0000);
        rst_n = 1;
        @(negedge clk);
        check("R1", {ie_flag, tf_flag, irq_accept, dbg_trap}, 4'b0000);

        // R2 / R3: privilege sweep over pops
        for (int oie = 0; oie < 2; oie++)
            for (int pr = 0; pr < 4; pr++)
                for (int io = 0; io < 4; io++)
                    for (int v = 0; v < 4; v++) begin
                        logic nie, ntf, eie;
                        nie = v[1]; ntf = v[0];
                        set_flags(oie[0], ~ntf);
                        pop_we = 1; cur_priv = pr[1:0]; pop_data = word(io[1:0], nie, ntf);
                        @(negedge clk);
                        eie = (pr <= io) ? nie : oie[0];
                        check((pr <= io) ? "R2" : "R3",
                              {ie_flag, tf_flag, irq_accept, dbg_trap}, {eie, ntf, 2'b00});
                        idle();
                    end

        // R4-R9: decision sweep
        for (int ie = 0; ie < 2; ie++)
            for (int tf = 0; tf < 2; tf++)
                for (int rq = 0; rq < 2; rq++)
                    for (int rt = 0; rt < 2; rt++)
                        for (int bk = 0; bk < 16; bk++) begin
                            logic etrap, eacc;
                            set_flags(ie[0], tf[0]);
                            retire = rt[0]; ext_irq_req = rq[0]; bkpt_hit = bk[3:0];
                            @(negedge clk);
                            etrap = rt[0] && (tf[0] || (bk != 0));
                            eacc  = rt[0] && ie[0] && rq[0] && !etrap;
                            check(!rt[0] ? "R9" : (etrap && eacc) ? "R8" :
                                  etrap ? (tf[0] ? "R6" : "R7") :
                                  eacc ? "R4" : (ie[0] ? "R7" : "R5"),
                                  {ie_flag, tf_flag, irq_accept, dbg_trap},
                                  {ie[0] && !eacc, tf[0], eacc, etrap});
                            idle();
                        end

        // R8: interrupt still taken at a later retire
        set_flags(1, 0);
        retire = 1; ext_irq_req = 1; bkpt_hit = 4'b0100;
        @(negedge clk);
        check("R8", {ie_flag, tf_flag, irq_accept, dbg_trap}, 4'b1001);
        retire = 1; ext_irq_req = 1; bkpt_hit = 0;
        @(negedge clk);
        check("R8", {ie_flag, tf_flag, irq_accept, dbg_trap}, 4'b0010);
        idle();
        @(negedge clk);
        check("R4", {ie_flag, tf_flag, irq_accept, dbg_trap}, 4'b0000);

        // R10: accept and pop in the same cycle
        set_flags(1, 0);
        retire = 1; ext_irq_req = 1; pop_we = 1; cur_priv = 0; pop_data = word(2'd3, 1, 1);
        @(negedge clk);
        check("R10", {ie_flag, tf_flag, irq_accept, dbg_trap}, 4'b0110);
        idle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule